// File: doc/BRIEF.md
# Split-Half SEC-DED Check Generator

This block produces check fields for the write path of a memory that stores two bits per cell. A 32-bit word is cut into an upper group (bits 31..16, the group stored as the most significant bit of each cell) and a lower group (bits 15..0). Two identical encoders work on the two groups in parallel, so both fields are ready in the same cycle. Each encoder emits five Hamming check bits and one total-parity bit for its group. The two 6-bit fields are kept apart because the read side checks each group at a different time. That way a single corrupted cell, which may flip both of its bits, shows up as one error in each group and not as a double error in one group.

Each encoder builds its total-parity bit from two of its own Hamming bits, which cover disjoint ranges of data bits, plus the four lowest data bits. This needs five two-input XORs instead of a full sixteen-input tree. The encoder is a pure function with no parameters, so the read path can reuse it to regenerate check bits. A parameter selects an optional output register stage.

Top module: `split_chk_gen`

## Requirements
- R1: `lsb_chk_o` depends only on `data_i[15:0]` and `msb_chk_o` depends only on `data_i[31:16]`. Changing one group leaves the other group's field unchanged.
- R2: In each field, bits [4:0], read as a number, equal the XOR of the code positions of all set data bits. Data bits 0..15 have the positions 3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15, 17, 18, 19, 20, 21 in that order. Field bit 4 has weight 16 and field bit 0 has weight 1.
- R3: A group whose only set bit is bit 2 gives field bits [4:0] = 6. A group whose only set bit is bit 7 gives 12.
- R4: Field bit 3 is the parity of data bits 4..10, and field bit 4 is the parity of data bits 11..15.
- R5: Field bit 5 is the parity of all 16 data bits of the group.
- R6: The sixteen single-bit group words give sixteen distinct nonzero values in field bits [4:0], and none of them is a power of two.
- R7: An all-zero group gives an all-zero field.
- R8: With `OUT_REG` = 1 (the default), both fields are registered. The fields are zero while `rst_n` is low, and each field reflects the input one clock edge after that input was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| data_i | input | 32 | Word to be written; [31:16] upper group, [15:0] lower group |
| msb_chk_o | output | 6 | Check field of the upper group: [5] total parity, [4:0] Hamming bits |
| lsb_chk_o | output | 6 | Check field of the lower group: [5] total parity, [4:0] Hamming bits |

## Verification
The hardest case to reach from the ports is the folded parity bit disagreeing with a true sixteen-input parity. This can only happen for particular mixes of bits across the ranges that the two reused Hamming bits cover. The bench therefore sweeps all 65536 values of the lower group. At the same time the upper group runs through an odd-multiplier permutation, so it also visits every value, and every pattern is compared against positions and parities computed arithmetically in the bench. Single-bit words and words that change only one group are added on top, to check that each bit has its own syndrome and that the two groups are isolated.

// File: rtl/mlc_chk_pkg.sv
package mlc_chk_pkg;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned SYN_W   = 5;
  localparam int unsigned FLD_W   = SYN_W + 1;
  localparam int unsigned WORD_W  = 2 * HALF_W;
  // data bits below the range covered by the weight-8 check bit
  localparam int unsigned LOW_W   = 4;
  localparam int unsigned POS_LIM = 64;

  // code position of data bit idx: the idx-th non-power-of-two from 3 upward
  function automatic int unsigned pos_of(input int unsigned idx);
    int unsigned n;
    int unsigned res;
    n   = 0;
    res = 0;
    for (int unsigned p = 3; p < POS_LIM; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx && res == 0) res = p;
        n++;
      end
    end
    return res;
  endfunction

  // set of data bits covered by the check bit of binary weight 2**w
  function automatic logic [HALF_W-1:0] weight_mask(input int unsigned w);
    logic [HALF_W-1:0] m;
    int unsigned p;
    for (int unsigned i = 0; i < HALF_W; i++) begin
      p    = pos_of(i);
      m[i] = ((p >> w) & 1) != 0;
    end
    return m;
  endfunction
endpackage

// File: rtl/mlc_weight_tree.sv
module mlc_weight_tree
  import mlc_chk_pkg::*;
#(
  parameter int unsigned W_IDX = 0
) (
  input  logic [HALF_W-1:0] grp_i,
  output logic              bit_o
);
  localparam logic [HALF_W-1:0] COVER = weight_mask(W_IDX);

  logic [HALF_W-1:0] picked;
  assign picked = grp_i & COVER;
  assign bit_o  = ^picked;
endmodule

// File: rtl/mlc_half_encoder.sv
module mlc_half_encoder
  import mlc_chk_pkg::*;
(
  input  logic [HALF_W-1:0] grp_i,
  output logic [FLD_W-1:0]  fld_o
);
  logic [SYN_W-1:0] syn_w;
  logic             low_par_w;
  logic             fold_par_w;

  for (genvar w = 0; w < SYN_W; w++) begin : g_tree
    mlc_weight_tree #(.W_IDX(w)) u_tree (
      .grp_i (grp_i),
      .bit_o (syn_w[w])
    );
  end

  // weight-16 and weight-8 bits cover disjoint ranges above the low bits
  assign low_par_w  = ^grp_i[LOW_W-1:0];
  assign fold_par_w = syn_w[SYN_W-1] ^ syn_w[SYN_W-2] ^ low_par_w;

  assign fld_o = {fold_par_w, syn_w};
endmodule

// File: rtl/split_chk_gen.sv
module split_chk_gen
  import mlc_chk_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] data_i,
  output logic [FLD_W-1:0]  msb_chk_o,
  output logic [FLD_W-1:0]  lsb_chk_o
);
  logic [FLD_W-1:0] fld_w [2];

  for (genvar g = 0; g < 2; g++) begin : g_half
    mlc_half_encoder u_enc (
      .grp_i (data_i[g*HALF_W +: HALF_W]),
      .fld_o (fld_w[g])
    );
  end

  logic [FLD_W-1:0] lsb_fld_w;
  logic [FLD_W-1:0] msb_fld_w;
  assign lsb_fld_w = fld_w[0];
  assign msb_fld_w = fld_w[1];

  if (OUT_REG) begin : g_reg
    logic [FLD_W-1:0] msb_q;
    logic [FLD_W-1:0] lsb_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        msb_q <= '0;
        lsb_q <= '0;
      end else begin
        msb_q <= msb_fld_w;
        lsb_q <= lsb_fld_w;
      end
    end
    assign msb_chk_o = msb_q;
    assign lsb_chk_o = lsb_q;

    // R1
    msb_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(data_i[WORD_W-1:HALF_W])) |=> $stable(msb_chk_o));
    // R1
    lsb_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(data_i[HALF_W-1:0])) |=> $stable(lsb_chk_o));
    // R7
    zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_i == '0) |=> (msb_chk_o == '0 && lsb_chk_o == '0));
  end else begin : g_comb
    assign msb_chk_o = msb_fld_w;
    assign lsb_chk_o = lsb_fld_w;
  end

  // R5
  lsb_parity_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsb_fld_w[FLD_W-1] == ^data_i[HALF_W-1:0]);
  // R5
  msb_parity_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msb_fld_w[FLD_W-1] == ^data_i[WORD_W-1:HALF_W]);
endmodule

// File: tb/split_chk_gen_tb.sv
module split_chk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data = '0;
  logic [5:0]  msb_chk;
  logic [5:0]  lsb_chk;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  split_chk_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_i    (data),
    .msb_chk_o (msb_chk),
    .lsb_chk_o (lsb_chk)
  );

  function automatic int unsigned posn(input int unsigned i);
    case (i)
      0: return 3;   1: return 5;   2: return 6;   3: return 7;
      4: return 9;   5: return 10;  6: return 11;  7: return 12;
      8: return 13;  9: return 14;  10: return 15; 11: return 17;
      12: return 18; 13: return 19; 14: return 20; default: return 21;
    endcase
  endfunction

  function automatic logic [5:0] expect_fld(input logic [15:0] d);
    int unsigned syn;
    logic par;
    syn = 0;
    par = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (d[i]) begin
        syn = syn ^ posn(i);
        par = ~par;
      end
    end
    return {par, syn[4:0]};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    while (cyc < 190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<190000", cyc);
    summary();
  end

  initial begin
    logic [15:0] prev_lo;
    logic [15:0] prev_hi;
    logic [31:0] seen;
    // R8 reset state
    repeat (3) @(negedge clk);
    data = 32'hFFFF_1234;
    @(negedge clk);
    check("R8 reset msb", msb_chk, 6'h0);
    check("R8 reset lsb", lsb_chk, 6'h0);
    rst_n = 1'b1;
    // R8 latency: before the first edge after release, still zero
    check("R8 pre-edge", lsb_chk, 6'h0);
    @(negedge clk);
    check("R8 one edge lsb", lsb_chk, expect_fld(16'h1234));
    check("R8 one edge msb", msb_chk, expect_fld(16'hFFFF));

    // R7 zero word
    data = '0;
    @(negedge clk);
    check("R7 zero lsb", lsb_chk, 6'h0);
    check("R7 zero msb", msb_chk, 6'h0);

    // R3, R6 single-bit words
    seen = '0;
    for (int i = 0; i < 16; i++) begin
      data = 32'h1 << i;
      @(negedge clk);
      if (i == 2) check("R3 bit2", {1'b0, lsb_chk[4:0]}, 6'd6);
      if (i == 7) check("R3 bit7", {1'b0, lsb_chk[4:0]}, 6'd12);
      check("R2 single", lsb_chk, expect_fld(16'h1 << i));
      n_chk++;
      if (lsb_chk[4:0] == 0 || (lsb_chk[4:0] & (lsb_chk[4:0] - 5'd1)) == 0
          || seen[lsb_chk[4:0]]) begin
        n_bad++;
        $display("FAIL R6 actual=%0d expected=distinct non-power-of-two", lsb_chk[4:0]);
      end
      seen[lsb_chk[4:0]] = 1'b1;
    end

    // R1 isolation: change upper group only, then lower only
    data = 32'h0000_A5C3;
    @(negedge clk);
    data = 32'h7E11_A5C3;
    @(negedge clk);
    check("R1 lsb unchanged", lsb_chk, expect_fld(16'hA5C3));
    data = 32'h7E11_0F0F;
    @(negedge clk);
    check("R1 msb unchanged", msb_chk, expect_fld(16'h7E11));

    // R2 R4 R5 sweep: lower exhaustive, upper an odd-multiplier permutation
    prev_lo = data[15:0];
    prev_hi = data[31:16];
    for (int v = 0; v < 65536; v++) begin
      logic [15:0] lo;
      logic [15:0] hi;
      lo = v[15:0];
      hi = (v[15:0] * 16'd40503) ^ 16'h5A5A;
      data = {hi, lo};
      @(negedge clk);
      check("R2 lsb", lsb_chk, expect_fld(lo));
      check("R2 msb", msb_chk, expect_fld(hi));
      check("R4 weight8", {5'b0, lsb_chk[3]}, {5'b0, ^lo[10:4]});
      check("R4 weight16", {5'b0, msb_chk[4]}, {5'b0, ^hi[15:11]});
      check("R5 parity", {5'b0, lsb_chk[5]}, {5'b0, ^lo});
    end
    summary();
  end
endmodule